// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Engine

This block turns a system clock into the quantum-level timing of a CAN bit. A programmable divider produces a one-cycle quantum enable. A segment sequencer splits every bit into four parts: a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. It marks the sample point and the start of each bit with one-cycle strobes. At the sample point it captures the received line level and holds it until the next sample.

The received line is watched for recessive-to-dominant transitions. When the frame layer allows hard synchronization, such a transition restarts the bit as though the sync segment has just finished. Otherwise the engine measures the phase error and corrects the bit by at most the programmed jump width. It can stretch the first phase segment or cut the second one short. This correction happens at most once per bit, and never while the local node is driving a dominant level. The timing fields load only while the freeze input is high. While frozen, the engine stays parked at the start of a bit.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick_o` is high for one cycle out of every (cfg_presc_i + 1) system cycles while not frozen. After reset the divider field is 0, so the tick is high on every cycle.
- R2: Each bit without correction lasts 1 + (prop+1) + (ph1+1) + (ph2q) quanta. `bit_start_o` pulses in the first cycle of each bit. `sample_o` pulses (3 + prop + ph1) quanta after `bit_start_o`, that is, in the cycle after the last quantum of the first phase segment.
- R3: `sample_o` is a single-cycle pulse and never coincides with `bit_start_o`. `rx_bit_o` takes the `rx_i` level present at the end of the first phase segment and holds it. It resets to 1 (recessive).
- R4: The second phase segment lasts ph2q quanta, where ph2q = cfg_ph2_i + 1 for values 1 to 7. A field value of 0 is treated as 1, which gives 2 quanta.
- R5: The timing fields (divider, jump code, prop, ph1, ph2) load only on a cycle where both `cfg_wr_i` and `freeze_i` are high. A write with `freeze_i` low has no effect. After reset all fields are 0.
- R6: While `freeze_i` is high, no tick, sample or bit-start pulse occurs. The cycle in which `freeze_i` falls is the first cycle of a sync segment.
- R7: With `hsync_en_i` high, a falling edge of `rx_i` (1 then 0 on consecutive cycles) restarts timing. `bit_start_o` pulses in the next cycle, the divider restarts, and that cycle begins the propagation segment. The next sample then follows after (prop+1 + ph1+1) quanta.
- R8: An edge seen at quantum q (counted from 0) of the propagation segment has error e = q+1. An edge at quantum q of the first phase segment has e = prop+1+q+1. In both cases the first phase segment is lengthened by min(e, cfg_rjw_i+1) quanta.
- R9: An edge at quantum q of the second phase segment shortens that segment by min(ph2q - q, cfg_rjw_i+1) quanta, and never below the quantum in progress.
- R10: At most one correction is applied per bit, and an edge during the sync segment causes none.
- R11: No correction is applied to an edge seen while `tx_dom_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Holds the engine and opens the timing fields for writing |
| cfg_wr_i | input | 1 | Load strobe for the timing fields |
| cfg_presc_i | input | 8 | Divider code, quantum = code+1 system cycles |
| cfg_rjw_i | input | 2 | Jump width code, width = code+1 quanta |
| cfg_prop_i | input | 3 | Propagation segment code, length = code+1 |
| cfg_ph1_i | input | 3 | First phase segment code, length = code+1 |
| cfg_ph2_i | input | 3 | Second phase segment code, length = code+1, 0 read as 1 |
| rx_i | input | 1 | Received bus level, 1 recessive |
| hsync_en_i | input | 1 | Bus idle, hard synchronization allowed |
| tx_dom_i | input | 1 | Local node is driving a dominant level |
| tq_tick_o | output | 1 | Quantum enable |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Level captured at the last sample point |
| bit_start_o | output | 1 | First cycle of a bit |

## Verification
A segment counter or divider that drifts by a single quantum appears within one bit time. It shows up as a shifted gap between `bit_start_o` and `sample_o`, so the bench measures both gaps in cycles for every configuration. A wrong correction amount, a missed single-correction lock, or a correction applied while transmitting shows in the bit in which the edge occurs. There the sample offset or the bit length differs by one or two quanta from the value computed for that edge position. Configuration leaks outside freeze show on the next tick spacing.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
    localparam int PRESC_W = 8;
    localparam int JUMP_W  = 2;
    localparam int SEG_W   = 3;
    localparam int QCNT_W  = 5;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [JUMP_W-1:0] jump;
        logic [SEG_W-1:0]  prop;
        logic [SEG_W-1:0]  ph1;
        logic [SEG_W-1:0]  ph2;
    } seg_cfg_t;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        seg_cfg_t           seg;
    } timing_cfg_t;

    typedef logic [QCNT_W-1:0] qcnt_t;

    function automatic qcnt_t q_min(input qcnt_t a, input qcnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic qcnt_t jump_quanta(input seg_cfg_t c);
        return QCNT_W'(c.jump) + QCNT_W'(1);
    endfunction

    function automatic qcnt_t ph2_quanta(input seg_cfg_t c);
        return (c.ph2 == '0) ? QCNT_W'(2) : QCNT_W'(c.ph2) + QCNT_W'(1);
    endfunction
endpackage

// File: rtl/cbt_cfg_reg.sv
`timescale 1ns/1ps
module cbt_cfg_reg
    import cbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        freeze_i,
    input  logic        wr_i,
    input  timing_cfg_t cfg_d,
    output timing_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_i && freeze_i)
            cfg_q <= cfg_d;
    end
endmodule

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler
    import cbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);
    logic [PRESC_W-1:0] cnt_q;

    assign tick_o = !hold_i && (cnt_q == presc_i);

    always_ff @(posedge clk) begin
        if (rst || hold_i || restart_i)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + PRESC_W'(1);
    end
endmodule

// File: rtl/cbt_seg_engine.sv
`timescale 1ns/1ps
module cbt_seg_engine
    import cbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_i,
    input  logic     tick_i,
    input  logic     rx_i,
    input  logic     hsync_en_i,
    input  logic     tx_dom_i,
    input  seg_cfg_t cfg_i,
    output logic     restart_o,
    output logic     sample_o,
    output logic     rx_bit_o,
    output logic     bit_start_o
);
    seg_e  seg_q;
    qcnt_t qcnt_q, ext_q, shr_q, ext_n, shr_n;
    qcnt_t err_pos, ph2_rem;
    logic  done_q, done_n, rx_q, fall;

    assign fall      = rx_q && !rx_i;
    assign restart_o = !hold_i && fall && hsync_en_i;

    // phase error evaluation for a soft correction
    always_comb begin
        ext_n   = ext_q;
        shr_n   = shr_q;
        done_n  = done_q;
        err_pos = '0;
        ph2_rem = '0;
        if (!hold_i && fall && !hsync_en_i && !tx_dom_i && !done_q) begin
            case (seg_q)
                SEG_PROP: begin
                    err_pos = qcnt_q + QCNT_W'(1);
                    ext_n   = q_min(err_pos, jump_quanta(cfg_i));
                    done_n  = 1'b1;
                end
                SEG_PH1: begin
                    err_pos = QCNT_W'(cfg_i.prop) + qcnt_q + QCNT_W'(2);
                    ext_n   = q_min(err_pos, jump_quanta(cfg_i));
                    done_n  = 1'b1;
                end
                SEG_PH2: begin
                    ph2_rem = ph2_quanta(cfg_i) - qcnt_q;
                    shr_n   = q_min(ph2_rem, jump_quanta(cfg_i));
                    done_n  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q        <= 1'b1;
            seg_q       <= SEG_SYNC;
            qcnt_q      <= '0;
            ext_q       <= '0;
            shr_q       <= '0;
            done_q      <= 1'b0;
            sample_o    <= 1'b0;
            bit_start_o <= 1'b0;
            rx_bit_o    <= 1'b1;
        end else begin
            rx_q <= rx_i;
            if (hold_i) begin
                seg_q       <= SEG_SYNC;
                qcnt_q      <= '0;
                ext_q       <= '0;
                shr_q       <= '0;
                done_q      <= 1'b0;
                sample_o    <= 1'b0;
                bit_start_o <= 1'b0;
            end else if (restart_o) begin
                seg_q       <= SEG_PROP;
                qcnt_q      <= '0;
                ext_q       <= '0;
                shr_q       <= '0;
                done_q      <= 1'b1;
                sample_o    <= 1'b0;
                bit_start_o <= 1'b1;
            end else begin
                sample_o    <= 1'b0;
                bit_start_o <= 1'b0;
                ext_q       <= ext_n;
                shr_q       <= shr_n;
                done_q      <= done_n;
                if (tick_i) begin
                    case (seg_q)
                        SEG_SYNC: begin
                            seg_q  <= SEG_PROP;
                            qcnt_q <= '0;
                        end
                        SEG_PROP: begin
                            if (qcnt_q == QCNT_W'(cfg_i.prop)) begin
                                seg_q  <= SEG_PH1;
                                qcnt_q <= '0;
                            end else
                                qcnt_q <= qcnt_q + QCNT_W'(1);
                        end
                        SEG_PH1: begin
                            if (qcnt_q == QCNT_W'(cfg_i.ph1) + ext_n) begin
                                seg_q    <= SEG_PH2;
                                qcnt_q   <= '0;
                                sample_o <= 1'b1;
                                rx_bit_o <= rx_i;
                            end else
                                qcnt_q <= qcnt_q + QCNT_W'(1);
                        end
                        default: begin
                            if (qcnt_q + QCNT_W'(1) >= ph2_quanta(cfg_i) - shr_n) begin
                                seg_q       <= SEG_SYNC;
                                qcnt_q      <= '0;
                                ext_q       <= '0;
                                shr_q       <= '0;
                                done_q      <= 1'b0;
                                bit_start_o <= 1'b1;
                            end else
                                qcnt_q <= qcnt_q + QCNT_W'(1);
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               freeze_i,
    input  logic               cfg_wr_i,
    input  logic [PRESC_W-1:0] cfg_presc_i,
    input  logic [JUMP_W-1:0]  cfg_rjw_i,
    input  logic [SEG_W-1:0]   cfg_prop_i,
    input  logic [SEG_W-1:0]   cfg_ph1_i,
    input  logic [SEG_W-1:0]   cfg_ph2_i,
    input  logic               rx_i,
    input  logic               hsync_en_i,
    input  logic               tx_dom_i,
    output logic               tq_tick_o,
    output logic               sample_o,
    output logic               rx_bit_o,
    output logic               bit_start_o
);
    timing_cfg_t cfg_d, cfg_q;
    logic        restart;

    always_comb begin
        cfg_d.presc    = cfg_presc_i;
        cfg_d.seg.jump = cfg_rjw_i;
        cfg_d.seg.prop = cfg_prop_i;
        cfg_d.seg.ph1  = cfg_ph1_i;
        cfg_d.seg.ph2  = cfg_ph2_i;
    end

    cbt_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .freeze_i (freeze_i),
        .wr_i     (cfg_wr_i),
        .cfg_d    (cfg_d),
        .cfg_q    (cfg_q)
    );

    cbt_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (freeze_i),
        .restart_i (restart),
        .presc_i   (cfg_q.presc),
        .tick_o    (tq_tick_o)
    );

    cbt_seg_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (freeze_i),
        .tick_i      (tq_tick_o),
        .rx_i        (rx_i),
        .hsync_en_i  (hsync_en_i),
        .tx_dom_i    (tx_dom_i),
        .cfg_i       (cfg_q.seg),
        .restart_o   (restart),
        .sample_o    (sample_o),
        .rx_bit_o    (rx_bit_o),
        .bit_start_o (bit_start_o)
    );
endmodule

// File: rtl/cbt_checker.sv
`timescale 1ns/1ps
module cbt_checker
    import cbt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        freeze_i,
    input logic        tq_tick_o,
    input logic        sample_o,
    input logic        bit_start_o,
    input timing_cfg_t cfg_q
);
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tq_tick_o && cfg_q.presc != '0) |=> !tq_tick_o);

    assert_sample_on_quantum_R2: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> $past(tq_tick_o));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(sample_o && bit_start_o));

    assert_sample_single_R3: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o);

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> $stable(cfg_q));

    assert_frozen_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        freeze_i |-> !tq_tick_o);

    assert_frozen_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> (!sample_o && !bit_start_o));
endmodule

bind can_bit_timer cbt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .freeze_i    (freeze_i),
    .tq_tick_o   (tq_tick_o),
    .sample_o    (sample_o),
    .bit_start_o (bit_start_o),
    .cfg_q       (cfg_q)
);

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       freeze_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_presc_i = '0;
    logic [1:0] cfg_rjw_i = '0;
    logic [2:0] cfg_prop_i = '0;
    logic [2:0] cfg_ph1_i = '0;
    logic [2:0] cfg_ph2_i = '0;
    logic       rx_i = 1'b1;
    logic       hsync_en_i = 1'b0;
    logic       tx_dom_i = 1'b0;
    logic       tq_tick_o, sample_o, rx_bit_o, bit_start_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_bit_timer dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int smp_q(input int prop, input int ph1);
        return 3 + prop + ph1;
    endfunction

    function automatic int ph2_q(input int ph2);
        return (ph2 == 0) ? 2 : ph2 + 1;
    endfunction

    task automatic wait_bstart(output int c);
        int g = 0;
        do begin @(negedge clk); g++; end while (!bit_start_o && g < 5000);
        if (g >= 5000) chk(1'b0, "timeout bit_start", g, 0);
        c = cyc;
    endtask

    task automatic wait_sample(output int c);
        int g = 0;
        do begin @(negedge clk); g++; end while (!sample_o && g < 5000);
        if (g >= 5000) chk(1'b0, "timeout sample", g, 0);
        c = cyc;
    endtask

    task automatic wait_tick(output int c);
        int g = 0;
        do begin @(negedge clk); g++; end while (!tq_tick_o && g < 5000);
        if (g >= 5000) chk(1'b0, "timeout tick", g, 0);
        c = cyc;
    endtask

    task automatic prog(input int p, input int j, input int pr, input int a, input int b);
        @(negedge clk);
        freeze_i = 1'b1;
        cfg_presc_i = 8'(p); cfg_rjw_i = 2'(j);
        cfg_prop_i = 3'(pr); cfg_ph1_i = 3'(a); cfg_ph2_i = 3'(b);
        cfg_wr_i = 1'b1;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        @(negedge clk);
        freeze_i = 1'b0;
    endtask

    // edge k cycles after a bit start, then check sample offset and bit length
    task automatic edge_case(input int k, input int exp_s, input int exp_p, input string req);
        int t0, ts, t1;
        rx_i = 1'b1;
        wait_bstart(t0);
        wait_bstart(t0);
        if (k == 0) #1 rx_i = 1'b0;
        else begin
            repeat (k) @(posedge clk);
            #1 rx_i = 1'b0;
        end
        if (exp_s > 0) begin
            wait_sample(ts);
            chk(ts - t0 == exp_s, {req, " sample offset"}, ts - t0, exp_s);
        end
        wait_bstart(t1);
        chk(t1 - t0 == exp_p, {req, " bit length"}, t1 - t0, exp_p);
        rx_i = 1'b1;
    endtask

    initial begin
        int t0, ts, t1, a, b, seen, r, dummy;
        dummy = $urandom(32'd4242);
        // reset state
        repeat (3) @(negedge clk);
        chk(sample_o == 0 && bit_start_o == 0, "R3 reset strobes", int'(sample_o), 0);
        chk(rx_bit_o == 1'b1, "R3 reset rx_bit", int'(rx_bit_o), 1);
        @(negedge clk) rst = 1'b0;
        // R1: default divider gives a tick every cycle
        seen = 0;
        repeat (4) begin @(negedge clk); if (tq_tick_o) seen++; end
        chk(seen == 4, "R1 default tick rate", seen, 4);
        // R2, R4 defaults: all fields 0, ph2 read as 1
        wait_bstart(t0); wait_sample(ts); wait_bstart(t1);
        chk(ts - t0 == 3, "R2 default sample offset", ts - t0, 3);
        chk(t1 - ts == 2, "R4 default ph2 clamp", t1 - ts, 2);
        // R5: write while not frozen ignored
        @(negedge clk);
        cfg_presc_i = 8'd5; cfg_ph2_i = 3'd7; cfg_wr_i = 1'b1;
        @(negedge clk) cfg_wr_i = 1'b0;
        wait_tick(a); wait_tick(b);
        chk(b - a == 1, "R5 unfrozen write ignored (tick)", b - a, 1);
        wait_sample(ts); wait_bstart(t1);
        chk(t1 - ts == 2, "R5 unfrozen write ignored (ph2)", t1 - ts, 2);
        // R4 with divider
        prog(1, 0, 0, 0, 0);
        wait_sample(ts); wait_bstart(t1);
        chk(t1 - ts == 4, "R4 ph2 zero clamp", t1 - ts, 4);
        // R6: frozen silence and restart
        @(negedge clk) freeze_i = 1'b1;
        seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (tq_tick_o || sample_o || bit_start_o) seen++;
        end
        chk(seen == 0, "R6 frozen pulses", seen, 0);
        freeze_i = 1'b0;
        r = cyc;
        wait_sample(ts);
        chk(ts - r == 6, "R6 restart at sync", ts - r, 6);

        // random configurations, rx value per bit, transmitter dominant blocks correction
        tx_dom_i = 1'b1;
        for (int i = 0; i < 16; i++) begin
            int p, j, pr, f1, f2;
            p = int'($urandom_range(0, 7)); j = int'($urandom_range(0, 3));
            pr = int'($urandom_range(0, 7)); f1 = int'($urandom_range(0, 7));
            f2 = (i == 3) ? 0 : int'($urandom_range(0, 7));
            prog(p, j, pr, f1, f2);
            wait_tick(a); wait_tick(b);
            chk(b - a == p + 1, "R1 tick spacing", b - a, p + 1);
            for (int k = 0; k < 2; k++) begin
                bit v;
                v = 1'($urandom_range(0, 1));
                wait_bstart(t0);
                @(posedge clk); #1 rx_i = v;
                wait_sample(ts);
                chk(ts - t0 == smp_q(pr, f1) * (p + 1), "R2 sample offset", ts - t0, smp_q(pr, f1) * (p + 1));
                chk(rx_bit_o == v, "R3 sampled level", int'(rx_bit_o), int'(v));
                wait_bstart(t1);
                chk(t1 - ts == ph2_q(f2) * (p + 1), "R4 ph2 length", t1 - ts, ph2_q(f2) * (p + 1));
                rx_i = 1'b1;
            end
        end
        tx_dom_i = 1'b0;

        // directed corrections: 1 tick/cycle, prop 2q, ph1 3q, ph2 3q, jump 2q
        prog(0, 1, 1, 2, 2);
        edge_case(1, 7, 10, "R8 early edge e=1");
        chk(rx_bit_o == 1'b0, "R3 dominant sampled", int'(rx_bit_o), 0);
        edge_case(5, 8, 11, "R8 late edge capped");
        edge_case(6, 0, 7, "R9 ph2 q0 capped");
        edge_case(7, 0, 8, "R9 ph2 q1");
        edge_case(0, 6, 9, "R10 edge in sync");
        tx_dom_i = 1'b1;
        edge_case(1, 6, 9, "R11 transmitting");
        tx_dom_i = 1'b0;
        // R10: second edge in same bit ignored
        rx_i = 1'b1;
        wait_bstart(t0); wait_bstart(t0);
        @(posedge clk); #1 rx_i = 1'b0;
        repeat (2) @(posedge clk); #1 rx_i = 1'b1;
        @(posedge clk); #1 rx_i = 1'b0;
        wait_sample(ts);
        chk(ts - t0 == 7, "R10 one correction per bit", ts - t0, 7);
        rx_i = 1'b1;
        // R7: hard sync
        hsync_en_i = 1'b1;
        wait_bstart(t0); wait_bstart(t0);
        repeat (3) @(posedge clk); #1 rx_i = 1'b0;
        wait_bstart(t1);
        chk(t1 - t0 == 4, "R7 hard sync bit start", t1 - t0, 4);
        wait_sample(ts);
        chk(ts - t1 == 5, "R7 sample after hard sync", ts - t1, 5);
        hsync_en_i = 1'b0;
        rx_i = 1'b1;
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule